// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Parallel-Bus Sequencer

This block sits on the host side of a six-channel, 16-bit simultaneous-sampling converter that has a parallel data bus. After system reset it drives the converter's reset line high for a set number of clock cycles. It then lets the line settle low. In software mode it writes one control word, and then it waits in idle. Each conversion request gives a complete convert-start pulse: the line, which rests high, goes low and then returns high. The block then watches the converter's busy line. When busy falls, it reads the six results in order, starting at channel 0 and ending at channel 5. Each read asserts chip-select together with the read strobe.

Results leave on a stream made of a one-cycle valid pulse, a 3-bit channel tag and a 16-bit value. Word mode reads each result in one transfer. Byte mode makes two transfers on the upper eight data lines. The high-byte select (wired to data line 7 on the board) is low for the low byte and high for the high byte, and the block joins the two bytes into one word.

The range-select level is taken when a conversion is accepted. It is then held steady until the reads are done, so the converter sees a stable level when busy falls. A re-initialise request waits for the current read burst to finish. A busy timeout raises a sticky error flag.

The FSM states are S_RST_HI, S_RST_LO, S_WR_STRB, S_WR_GAP, S_IDLE, S_CONV_LO, S_WAIT_BUSY, S_RD_STRB and S_RD_GAP. The transitions are:
- S_RST_HI → S_RST_LO when the reset width has elapsed.
- S_RST_LO → S_WR_STRB in software mode, or → S_IDLE otherwise.
- S_WR_STRB → S_WR_GAP → S_IDLE.
- S_IDLE → S_RST_HI on a re-initialise request, or → S_CONV_LO on a conversion request when not in standby.
- S_CONV_LO → S_WAIT_BUSY.
- S_WAIT_BUSY → S_RD_STRB on a busy fall, or → S_IDLE on timeout.
- S_RD_STRB → S_RD_GAP.
- S_RD_GAP → S_RD_STRB while transfers remain, or → S_IDLE after the last one.

Top module: `adc_bus_seq`

## Requirements
- R1: After rst_n is released, adc_reset stays high for exactly RST_CYC cycles. It is high throughout rst_n low.
- R2: adc_convst rests high and is never low while adc_reset is high. Each accepted conversion drives it low for exactly CONV_LO_CYC cycles and then high again.
- R3: After each busy fall, exactly six results are emitted as one-cycle res_valid pulses, with res_chan taking the values 0, 1, 2, 3, 4 and 5 in that order. res_valid is low during reset.
- R4: In word mode (cfg_byte_mode=0), each read holds adc_cs_n and adc_rd_n low together for STRB_CYC cycles. adc_rd_n and adc_wr_n are never low at once. The result is adc_db_in[15:0], taken in the last strobe cycle.
- R5: In byte mode (cfg_byte_mode=1), each channel takes two reads. The first has adc_hben=0 and returns the low byte on adc_db_in[15:8]. The second has adc_hben=1 and returns the high byte there. res_data is {high byte, low byte}.
- R6: adc_range takes cfg_range_sel when a conversion is accepted and holds it until the sequencer is idle again, so the level at the busy fall matches the request (1 = narrower range, 0 = wider range).
- R7: With cfg_soft_mode=1 at the end of a reset pulse, one write follows. It holds adc_cs_n and adc_wr_n low together with adc_db_oe high and adc_db_out equal to cfg_ctrl_word. With cfg_soft_mode=0, no write occurs.
- R8: A reinit_req pulse in idle starts a new reset pulse. A pulse during a conversion or a read burst is held until all six results are out, and then one reset pulse follows.
- R9: If busy does not fall within BUSY_TMO cycles of the convert-start rising edge, busy_err is set and the sequencer returns to idle without reading. busy_err stays set until rst_n.
- R10: adc_stby_n is the inverse of stby_req. While stby_req is high, conv_req is ignored and no convert-start pulse is issued.
- R11: seq_idle is high only in idle. A conv_req that arrives while not idle is ignored and gives no second convert-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | Request one conversion and read burst |
| reinit_req | input | 1 | Request a converter reset pulse |
| stby_req | input | 1 | Request converter standby |
| cfg_byte_mode | input | 1 | 1 = two byte transfers per result |
| cfg_soft_mode | input | 1 | 1 = write control word after each reset |
| cfg_range_sel | input | 1 | Range level for the next conversion |
| cfg_ctrl_word | input | 16 | Control word written in software mode |
| adc_reset | output | 1 | Converter reset, active high |
| adc_convst | output | 1 | Convert-start, conversion on rising edge |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_hben | output | 1 | High-byte select for byte mode |
| adc_range | output | 1 | Range-select level |
| adc_stby_n | output | 1 | Standby, low = standby |
| adc_db_out | output | 16 | Data bus drive value |
| adc_db_oe | output | 1 | Data bus drive enable |
| adc_busy | input | 1 | Converter busy |
| adc_db_in | input | 16 | Data bus read value |
| res_valid | output | 1 | Result valid pulse |
| res_chan | output | 3 | Result channel tag |
| res_data | output | 16 | Result value |
| busy_err | output | 1 | Sticky busy-timeout flag |
| seq_idle | output | 1 | Sequencer idle |

## Verification
The hardest cases to reach from the ports are a re-initialise request that lands mid-conversion and a busy line that never falls. The bench's converter model raises busy two cycles after each convert-start rising edge and holds it for twenty cycles. A run can pulse reinit_req or a second conv_req while busy is high. The bench then records how many results have come out when the reset line next rises. A mute switch in the model keeps busy low, which drives the sequencer into its timeout branch.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        S_RST_HI,
        S_RST_LO,
        S_WR_STRB,
        S_WR_GAP,
        S_IDLE,
        S_CONV_LO,
        S_WAIT_BUSY,
        S_RD_STRB,
        S_RD_GAP
    } seq_state_t;

endpackage

// File: rtl/adc_cycle_timer.sv
// Loadable down-counter; done is high while the count sits at zero.
module adc_cycle_timer #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R1/R2: the interval count steps down one per cycle when not reloaded
    a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/adc_busy_guard.sv
// Synchronises the busy line, flags its falling edge and times the wait.
module adc_busy_guard #(
    parameter int SYNC = 2,
    parameter int TMO  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_raw,
    input  logic arm,
    output logic busy_fall,
    output logic timeout
);

    localparam int TCW = $clog2(TMO + 1);

    logic [SYNC-1:0] sync_q;
    logic            busy_s;
    logic            busy_prev;
    logic [TCW-1:0]  wait_cnt;

    generate
        if (SYNC == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= busy_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC-2:0], busy_raw};
            end
        end
    endgenerate

    assign busy_s = sync_q[SYNC-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_prev <= 1'b0;
            wait_cnt  <= '0;
        end else begin
            busy_prev <= busy_s;
            if (!arm)          wait_cnt <= '0;
            else if (!timeout) wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign busy_fall = busy_prev && !busy_s;
    assign timeout   = arm && (wait_cnt == TCW'(TMO - 1));

endmodule

// File: rtl/adc_word_merge.sv
// Captures bus data at the end of a read strobe and forms results.
module adc_word_merge #(
    parameter int DW = 16,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          byte_mode,
    input  logic          hi_half,
    input  logic [CW-1:0] chan,
    input  logic [DW-1:0] db_in,
    output logic          out_valid,
    output logic [CW-1:0] out_chan,
    output logic [DW-1:0] out_data
);

    localparam int BW = DW / 2;

    logic [BW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (cap) begin
                if (byte_mode && !hi_half) begin
                    lo_q <= db_in[DW-1:BW];
                end else begin
                    out_valid <= 1'b1;
                    out_chan  <= chan;
                    out_data  <= byte_mode ? {db_in[DW-1:BW], lo_q} : db_in;
                end
            end
        end
    end

    // R3: a result pulse never lasts more than one cycle
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH         = 6,
    parameter int DW          = 16,
    parameter int RST_CYC     = 25,
    parameter int RST_GAP_CYC = 4,
    parameter int CONV_LO_CYC = 4,
    parameter int STRB_CYC    = 3,
    parameter int GAP_CYC     = 2,
    parameter int BUSY_TMO    = 1024,
    parameter int SYNC        = 2,
    localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_req,
    input  logic          reinit_req,
    input  logic          stby_req,
    input  logic          cfg_byte_mode,
    input  logic          cfg_soft_mode,
    input  logic          cfg_range_sel,
    input  logic [DW-1:0] cfg_ctrl_word,
    output logic          adc_reset,
    output logic          adc_convst,
    output logic          adc_cs_n,
    output logic          adc_rd_n,
    output logic          adc_wr_n,
    output logic          adc_hben,
    output logic          adc_range,
    output logic          adc_stby_n,
    output logic [DW-1:0] adc_db_out,
    output logic          adc_db_oe,
    input  logic          adc_busy,
    input  logic [DW-1:0] adc_db_in,
    output logic          res_valid,
    output logic [CW-1:0] res_chan,
    output logic [DW-1:0] res_data,
    output logic          busy_err,
    output logic          seq_idle
);

    localparam int MAX_A = (RST_CYC > RST_GAP_CYC) ? RST_CYC : RST_GAP_CYC;
    localparam int MAX_B = (CONV_LO_CYC > STRB_CYC) ? CONV_LO_CYC : STRB_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXC  = (MAX_C > GAP_CYC) ? MAX_C : GAP_CYC;
    localparam int TW    = $clog2(MAXC + 1);

    localparam logic [TW-1:0] LD_RST  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] LD_RGAP = TW'(RST_GAP_CYC - 1);
    localparam logic [TW-1:0] LD_CONV = TW'(CONV_LO_CYC - 1);
    localparam logic [TW-1:0] LD_STRB = TW'(STRB_CYC - 1);
    localparam logic [TW-1:0] LD_GAP  = TW'(GAP_CYC - 1);
    localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

    seq_state_t     state_q, state_d;
    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_done;
    logic           busy_fall, tmo_hit, cap;
    logic           range_q, byte_q, half_q, last_q, pend_q, err_q;
    logic [CW-1:0]  chan_q;
    logic [DW-1:0]  ctrl_q;

    // ---------------- sub-blocks ----------------
    adc_cycle_timer #(
        .W       (TW),
        .RST_VAL (LD_RST)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    adc_busy_guard #(
        .SYNC (SYNC),
        .TMO  (BUSY_TMO)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_raw  (adc_busy),
        .arm       (state_q == S_WAIT_BUSY),
        .busy_fall (busy_fall),
        .timeout   (tmo_hit)
    );

    assign cap = (state_q == S_RD_STRB) && tmr_done;

    adc_word_merge #(
        .DW (DW),
        .CW (CW)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .byte_mode (byte_q),
        .hi_half   (half_q),
        .chan      (chan_q),
        .db_in     (adc_db_in),
        .out_valid (res_valid),
        .out_chan  (res_chan),
        .out_data  (res_data)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_RST_HI: begin
                if (tmr_done) begin
                    state_d  = S_RST_LO;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RGAP;
                end
            end
            S_RST_LO: begin
                if (tmr_done) begin
                    if (cfg_soft_mode) begin
                        state_d  = S_WR_STRB;
                        tmr_load = 1'b1;
                        tmr_val  = LD_STRB;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_WR_STRB: begin
                if (tmr_done) begin
                    state_d  = S_WR_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_GAP;
                end
            end
            S_WR_GAP: begin
                if (tmr_done) state_d = S_IDLE;
            end
            S_IDLE: begin
                if (pend_q || reinit_req) begin
                    state_d  = S_RST_HI;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST;
                end else if (conv_req && !stby_req) begin
                    state_d  = S_CONV_LO;
                    tmr_load = 1'b1;
                    tmr_val  = LD_CONV;
                end
            end
            S_CONV_LO: begin
                if (tmr_done) state_d = S_WAIT_BUSY;
            end
            S_WAIT_BUSY: begin
                if (busy_fall) begin
                    state_d  = S_RD_STRB;
                    tmr_load = 1'b1;
                    tmr_val  = LD_STRB;
                end else if (tmo_hit) begin
                    state_d = S_IDLE;
                end
            end
            S_RD_STRB: begin
                if (tmr_done) begin
                    state_d  = S_RD_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_GAP;
                end
            end
            S_RD_GAP: begin
                if (tmr_done) begin
                    if (last_q) begin
                        state_d = S_IDLE;
                    end else begin
                        state_d  = S_RD_STRB;
                        tmr_load = 1'b1;
                        tmr_val  = LD_STRB;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RST_HI;
        else        state_q <= state_d;
    end

    // ---------------- sequencing registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= 1'b0;
            byte_q  <= 1'b0;
            half_q  <= 1'b0;
            last_q  <= 1'b0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
            chan_q  <= '0;
            ctrl_q  <= '0;
        end else begin
            if (state_q == S_IDLE && state_d == S_RST_HI) pend_q <= 1'b0;
            else if (reinit_req)                          pend_q <= 1'b1;

            if (state_q == S_IDLE && state_d == S_CONV_LO) begin
                range_q <= cfg_range_sel;
                byte_q  <= cfg_byte_mode;
            end

            if (state_q == S_RST_LO && tmr_done && cfg_soft_mode) ctrl_q <= cfg_ctrl_word;

            if (state_q == S_WAIT_BUSY && busy_fall) begin
                chan_q <= '0;
                half_q <= 1'b0;
                last_q <= 1'b0;
            end

            if (cap) begin
                if (byte_q && !half_q) begin
                    half_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                    chan_q <= chan_q + 1'b1;
                end
                last_q <= (chan_q == LAST_CH) && (!byte_q || half_q);
            end

            if (state_q == S_WAIT_BUSY && tmo_hit && !busy_fall) err_q <= 1'b1;
        end
    end

    // ---------------- output decode ----------------
    always_comb begin
        adc_reset  = 1'b0;
        adc_convst = 1'b1;
        adc_cs_n   = 1'b1;
        adc_rd_n   = 1'b1;
        adc_wr_n   = 1'b1;
        adc_db_oe  = 1'b0;
        adc_db_out = '0;
        seq_idle   = 1'b0;
        unique case (state_q)
            S_RST_HI:  adc_reset = 1'b1;
            S_CONV_LO: adc_convst = 1'b0;
            S_WR_STRB: begin
                adc_cs_n   = 1'b0;
                adc_wr_n   = 1'b0;
                adc_db_oe  = 1'b1;
                adc_db_out = ctrl_q;
            end
            S_RD_STRB: begin
                adc_cs_n = 1'b0;
                adc_rd_n = 1'b0;
            end
            S_IDLE:    seq_idle = 1'b1;
            default: ;
        endcase
    end

    assign adc_hben   = byte_q && half_q;
    assign adc_range  = range_q;
    assign adc_stby_n = !stby_req;
    assign busy_err   = err_q;

    // ---------------- assertions ----------------
    a_r2_convst_high_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset |-> adc_convst);

    a_r4_read_strobe_paired: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> (!adc_cs_n && adc_wr_n));

    a_r7_write_strobe_paired: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |-> (!adc_cs_n && adc_db_oe && adc_rd_n));

    a_r6_range_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && !$past(seq_idle)) |-> $stable(adc_range));

    a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ({1'b0, res_chan} < (CW + 1)'(NCH)));

    a_r8_reset_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_reset) |-> $past(seq_idle));

    a_r9_timeout_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_BUSY && tmo_hit && !busy_fall) |=> (seq_idle && busy_err));

    a_r10_no_convert_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && stby_req && !pend_q && !reinit_req) |=> adc_convst);

endmodule

// File: tb/tb_adc_bus_seq.sv
`timescale 1ns/1ps
module tb_adc_bus_seq;

    localparam int NCH = 6, DW = 16, RST_CYC = 25, RST_GAP_CYC = 4;
    localparam int CONV_LO_CYC = 4, STRB_CYC = 3, GAP_CYC = 2, BUSY_TMO = 1024;
    localparam int BUSY_HI = 20;

    // {byte_mode, range, seed}
    localparam logic [17:0] VEC [6] = '{
        {1'b0, 1'b1, 16'hA53C},
        {1'b1, 1'b0, 16'h1F80},
        {1'b0, 1'b0, 16'hFFFF},
        {1'b1, 1'b1, 16'h0001},
        {1'b1, 1'b0, 16'h8E47},
        {1'b0, 1'b1, 16'h0000}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, conv_req = 1'b0, reinit_req = 1'b0, stby_req = 1'b0;
    logic cfg_byte_mode = 1'b0, cfg_soft_mode = 1'b0, cfg_range_sel = 1'b0;
    logic [15:0] cfg_ctrl_word = 16'h0;
    logic adc_reset, adc_convst, adc_cs_n, adc_rd_n, adc_wr_n, adc_hben, adc_range, adc_stby_n;
    logic [15:0] adc_db_out, adc_db_in, res_data;
    logic adc_db_oe, adc_busy, res_valid, busy_err, seq_idle;
    logic [2:0] res_chan;

    adc_bus_seq #(
        .NCH(NCH), .DW(DW), .RST_CYC(RST_CYC), .RST_GAP_CYC(RST_GAP_CYC),
        .CONV_LO_CYC(CONV_LO_CYC), .STRB_CYC(STRB_CYC), .GAP_CYC(GAP_CYC),
        .BUSY_TMO(BUSY_TMO), .SYNC(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .reinit_req(reinit_req),
        .stby_req(stby_req), .cfg_byte_mode(cfg_byte_mode), .cfg_soft_mode(cfg_soft_mode),
        .cfg_range_sel(cfg_range_sel), .cfg_ctrl_word(cfg_ctrl_word),
        .adc_reset(adc_reset), .adc_convst(adc_convst), .adc_cs_n(adc_cs_n),
        .adc_rd_n(adc_rd_n), .adc_wr_n(adc_wr_n), .adc_hben(adc_hben),
        .adc_range(adc_range), .adc_stby_n(adc_stby_n), .adc_db_out(adc_db_out),
        .adc_db_oe(adc_db_oe), .adc_busy(adc_busy), .adc_db_in(adc_db_in),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .busy_err(busy_err), .seq_idle(seq_idle)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [15:0] seed, input int ch);
        return seed ^ (16'h1357 * 16'(ch + 1));
    endfunction

    // ---------------- converter model ----------------
    logic        mute_busy = 1'b0;
    int          bcnt = 0, xfers = 0;
    logic        cv_q = 1'b1, wr_q = 1'b1, rst_q = 1'b1;
    int          conv_pulses = 0, conv_lo_run = 0, conv_lo_bad = 0;
    int          rd_run = 0, rd_bad = 0, wr_cnt = 0, viol = 0, falls = 0;
    int          reset_rises = 0, res_at_reset = -1, exp_idx = 0;
    logic [15:0] wr_data = 16'h0, cur_seed = 16'h0;
    logic        range_at_fall = 1'b0;
    logic [15:0] model_word;

    assign adc_busy = (bcnt > 0) && (bcnt <= BUSY_HI);

    always_comb begin
        if (cfg_byte_mode) begin
            model_word = exp_word(cur_seed, xfers / 2);
            model_word = adc_hben ? {model_word[15:8], 8'h00} : {model_word[7:0], 8'h00};
        end else begin
            model_word = exp_word(cur_seed, xfers);
        end
    end
    assign adc_db_in = (!adc_cs_n && !adc_rd_n) ? model_word : 16'hFFFF;

    always @(negedge clk) begin
        if (!adc_convst) conv_lo_run++;
        else if (conv_lo_run != 0) begin
            if (conv_lo_run != CONV_LO_CYC) conv_lo_bad++;
            conv_lo_run = 0;
            conv_pulses++;
        end
        if (!cv_q && adc_convst && !mute_busy) begin
            bcnt  = BUSY_HI + 2;
            xfers = 0;
        end else if (bcnt > 0) begin
            if (bcnt == 1) begin
                range_at_fall = adc_range;
                falls++;
            end
            bcnt--;
        end
        cv_q = adc_convst;

        if (!adc_rd_n) rd_run++;
        else if (rd_run != 0) begin
            if (rd_run != STRB_CYC) rd_bad++;
            rd_run = 0;
            xfers++;
        end
        if (!adc_wr_n && !adc_cs_n && adc_db_oe) wr_data = adc_db_out;
        if (!wr_q && adc_wr_n) wr_cnt++;
        wr_q = adc_wr_n;

        if ((!adc_rd_n || !adc_wr_n) && adc_cs_n) viol++;
        if (!adc_rd_n && !adc_wr_n) viol++;
        if (adc_reset && !adc_convst) viol++;

        if (!rst_q && adc_reset) begin
            reset_rises++;
            res_at_reset = exp_idx;
        end
        rst_q = adc_reset;

        if (res_valid) begin
            check_eq("R3", "channel tag", 32'(res_chan), 32'(exp_idx));
            check_eq(cfg_byte_mode ? "R5" : "R4", "result data",
                     32'(res_data), 32'(exp_word(cur_seed, exp_idx)));
            exp_idx++;
        end
    end

    // ---------------- helpers ----------------
    task automatic wait_idle(input string req);
        bit ok = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (seq_idle) begin
                ok = 1'b1;
                break;
            end
        end
        check_eq(req, "reached idle", 32'(ok), 32'd1);
    endtask

    task automatic run_conv(input logic bm, input logic rng, input logic [15:0] seed,
                            input int inject);
        cfg_byte_mode = bm;
        cfg_range_sel = rng;
        cur_seed      = seed;
        exp_idx       = 0;
        @(posedge clk); #1 conv_req = 1'b1;
        @(posedge clk); #1 conv_req = 1'b0;
        if (inject != 0) begin
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (adc_busy) break;
            end
            @(posedge clk); #1;
            if (inject == 1) reinit_req = 1'b1; else conv_req = 1'b1;
            @(posedge clk); #1;
            reinit_req = 1'b0;
            conv_req   = 1'b0;
        end
        wait_idle("R11");
        repeat (2) @(negedge clk);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int w, p0, f0, rr0, w0;

        repeat (3) @(posedge clk);
        #1;
        check_eq("R1", "reset high in reset", 32'(adc_reset), 32'd1);
        check_eq("R2", "convst high in reset", 32'(adc_convst), 32'd1);
        check_eq("R4", "cs_n idle in reset", 32'(adc_cs_n), 32'd1);
        check_eq("R3", "valid low in reset", 32'(res_valid), 32'd0);
        check_eq("R9", "err clear in reset", 32'(busy_err), 32'd0);
        check_eq("R11", "not idle in reset", 32'(seq_idle), 32'd0);

        @(posedge clk); #1 rst_n = 1'b1;
        w = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (adc_reset) w++;
            else break;
        end
        check_eq("R1", "reset pulse width", 32'(w), 32'(RST_CYC));
        wait_idle("R1");
        check_eq("R7", "no write in hardware mode", 32'(wr_cnt), 32'd0);

        // vector table
        for (int i = 0; i < 6; i++) begin
            p0 = conv_pulses;
            f0 = falls;
            run_conv(VEC[i][17], VEC[i][16], VEC[i][15:0], 0);
            check_eq("R3", "result count", 32'(exp_idx), 32'(NCH));
            check_eq("R3", "busy falls", 32'(falls), 32'(f0 + 1));
            check_eq("R6", "range at busy fall", 32'(range_at_fall), 32'(VEC[i][16]));
            check_eq("R2", "one convert pulse", 32'(conv_pulses), 32'(p0 + 1));
        end
        check_eq("R2", "convert low width errors", 32'(conv_lo_bad), 32'd0);
        check_eq("R4", "strobe width errors", 32'(rd_bad), 32'd0);
        check_eq("R4", "strobe pairing violations", 32'(viol), 32'd0);
        check_eq("R9", "no error on normal runs", 32'(busy_err), 32'd0);

        // standby
        @(posedge clk); #1 stby_req = 1'b1;
        @(negedge clk);
        check_eq("R10", "standby pin low", 32'(adc_stby_n), 32'd0);
        p0 = conv_pulses;
        @(posedge clk); #1 conv_req = 1'b1;
        @(posedge clk); #1 conv_req = 1'b0;
        repeat (40) @(negedge clk);
        check_eq("R10", "no convert in standby", 32'(conv_pulses), 32'(p0));
        check_eq("R10", "still idle in standby", 32'(seq_idle), 32'd1);
        @(posedge clk); #1 stby_req = 1'b0;
        @(negedge clk);
        check_eq("R10", "standby pin high", 32'(adc_stby_n), 32'd1);

        // extra request during conversion ignored
        p0 = conv_pulses;
        run_conv(1'b0, 1'b1, 16'h7E81, 2);
        check_eq("R11", "single convert pulse", 32'(conv_pulses), 32'(p0 + 1));
        check_eq("R11", "six results only", 32'(exp_idx), 32'(NCH));

        // deferred re-initialise with software-mode write
        cfg_soft_mode = 1'b1;
        cfg_ctrl_word = 16'h0D2C;
        rr0 = reset_rises;
        w0  = wr_cnt;
        run_conv(1'b1, 1'b0, 16'h3C5A, 1);
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (reset_rises > rr0 && seq_idle) break;
        end
        check_eq("R8", "one reset pulse", 32'(reset_rises), 32'(rr0 + 1));
        check_eq("R8", "results before reset", 32'(res_at_reset), 32'(NCH));
        check_eq("R7", "one control write", 32'(wr_cnt), 32'(w0 + 1));
        check_eq("R7", "control word value", 32'(wr_data), 32'h0D2C);
        cfg_soft_mode = 1'b0;
        run_conv(1'b0, 1'b0, 16'h5AA5, 0);
        check_eq("R8", "results after reinit", 32'(exp_idx), 32'(NCH));

        // busy timeout
        mute_busy = 1'b1;
        run_conv(1'b0, 1'b1, 16'h1234, 0);
        check_eq("R9", "error after timeout", 32'(busy_err), 32'd1);
        check_eq("R9", "no reads after timeout", 32'(exp_idx), 32'd0);
        mute_busy = 1'b0;
        run_conv(1'b1, 1'b1, 16'hC0DE, 0);
        check_eq("R9", "error stays set", 32'(busy_err), 32'd1);
        check_eq("R3", "results after timeout", 32'(exp_idx), 32'(NCH));
        check_eq("R4", "final pairing violations", 32'(viol), 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule